// File: doc/BRIEF.md
# Packet Write Receiver with Trailing-Strobe Mask

This block sits on the interface clock side of a host-to-device streaming path. An external bus master delivers fixed-length packets of 16-bit words. It raises a write strobe once for each word. The block forwards every valid word to a downstream FIFO as a write request with its data. It also keeps a per-packet word counter.

The master is known to hold its strobe one clock too long at the end of every packet, and that extra cycle carries no data. The counter runs one step past the packet length. While it sits on that step, the FIFO write is suppressed and the counter then returns to zero, ready for the next packet.

A registered space flag tells the master whether the FIFO currently has room for at least one complete packet. The master samples this flag before it starts each packet.

Top module: `pkt_write_rx`

## Requirements
- R1: While the synchronous reset is high, the FIFO write request stays low whatever the strobe does, and the space flag reads 0 one clock after reset was sampled.
- R2: During a packet, each of the first PKT_WORDS strobe-high clocks raises the FIFO write request in the same cycle.
- R3: The strobe-high clock that follows the PKT_WORDS-th word of a packet produces no FIFO write, and the word count restarts at zero after it. The end step is the counter bit at position log2(PKT_WORDS), so PKT_WORDS must be a power of two.
- R4: In every cycle where a write is requested, the FIFO write data equals the strobe-side input data of that same cycle.
- R5: Clocks with the strobe low leave the word count unchanged. A packet paused partway through resumes, and it still gets exactly PKT_WORDS writes followed by one masked cycle.
- R6: Packets separated by a single idle clock, or by none, each receive a full PKT_WORDS writes followed by one masked cycle.
- R7: The space flag is registered. One clock after the fill level is sampled, it is 1 exactly when FIFO_DEPTH minus the fill level is at least PKT_WORDS.
- R8: A reset asserted partway through a packet discards the partial count. The next packet then gets a full PKT_WORDS writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| wrStrobe | input | 1 | Write strobe from the bus master |
| wrData | input | WORD_W | Word presented with the strobe |
| fifoLevel | input | $clog2(FIFO_DEPTH+1) | Number of words held in the downstream FIFO |
| fifoWrReq | output | 1 | Write request to the FIFO |
| fifoWrData | output | WORD_W | Data written into the FIFO |
| haveSpace | output | 1 | FIFO can take one more whole packet |

## Verification
The bench builds the block with PKT_WORDS = 8 and FIFO_DEPTH = 32. These values keep packets short enough that every word slot of every packet, including the masked end step, is checked cycle by cycle. The space flag is swept over every fill level from empty to full, so the threshold at 24 words is covered from both sides. The short packets also make it cheap to cover:
- back-to-back packets with no gap and with a one-clock gap,
- a pause partway through a packet,
- a reset partway through a packet.

// File: rtl/pkt_write_pkg.sv
package pkt_write_pkg;
  typedef struct packed {
    logic wrEnable;   // current strobe carries a valid word
    logic endStep;    // counter is on the masked trailing step
  } ctlStrobes_t;
endpackage

// File: rtl/pkt_write_ctl.sv
module pkt_write_ctl
  import pkt_write_pkg::*;
#(
  parameter int PKT_WORDS = 256
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrStrobe,
  output ctlStrobes_t ctlOut
);
  localparam int TERM_BIT = $clog2(PKT_WORDS);
  localparam int CNT_W    = TERM_BIT + 1;
  localparam logic [CNT_W-1:0] END_VAL = CNT_W'(PKT_WORDS);

  logic [CNT_W-1:0] wordCount;

  always_ff @(posedge clk) begin
    if (rst) begin
      wordCount <= '0;
    end else if (wrStrobe) begin
      if (wordCount[TERM_BIT]) wordCount <= '0;
      else                     wordCount <= wordCount + 1'b1;
    end
  end

  always_comb begin
    ctlOut.endStep  = wordCount[TERM_BIT];
    ctlOut.wrEnable = wrStrobe & ~wordCount[TERM_BIT] & ~rst;
  end

  // R3: after the end step the count restarts
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && wordCount == END_VAL) |=> (wordCount == '0));
  // R5: idle clocks hold the count
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !wrStrobe |=> $stable(wordCount));
  // R2: count never exceeds the end step, and it advances on valid words
  p_range_r2: assert property (@(posedge clk) disable iff (rst)
    wordCount <= END_VAL);
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (wrStrobe && wordCount < END_VAL) |=> (wordCount == $past(wordCount) + 1'b1));
  // R8: reset clears the count
  p_clear_r8: assert property (@(posedge clk)
    rst |=> (wordCount == '0));
endmodule

// File: rtl/pkt_write_dp.sv
module pkt_write_dp
  import pkt_write_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PKT_WORDS  = 256,
  parameter int FIFO_DEPTH = 4096
) (
  input  logic                            clk,
  input  logic                            rst,
  input  ctlStrobes_t                     ctlIn,
  input  logic [WORD_W-1:0]               wrData,
  input  logic [$clog2(FIFO_DEPTH+1)-1:0] fifoLevel,
  output logic                            fifoWrReq,
  output logic [WORD_W-1:0]               fifoWrData,
  output logic                            haveSpace
);
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1);
  localparam int FREE_W = LVL_W + 1;
  localparam logic [FREE_W-1:0] DEPTH_V = FREE_W'(FIFO_DEPTH);
  localparam logic [FREE_W-1:0] PKT_V   = FREE_W'(PKT_WORDS);

  logic [FREE_W-1:0] freeWords;
  logic              roomNow;

  always_comb begin
    freeWords  = DEPTH_V - FREE_W'(fifoLevel);
    roomNow    = (fifoLevel <= LVL_W'(FIFO_DEPTH)) && (freeWords >= PKT_V);
    fifoWrReq  = ctlIn.wrEnable;
    fifoWrData = wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) haveSpace <= 1'b0;
    else     haveSpace <= roomNow;
  end

  // R3: no write request on the trailing step
  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    ctlIn.endStep |-> !fifoWrReq);
  // R1: reset forces the flag low on the following clock
  p_reset_r1: assert property (@(posedge clk)
    rst |=> !haveSpace);
  // R7: a full FIFO never reports room
  p_full_r7: assert property (@(posedge clk) disable iff (rst)
    (fifoLevel == LVL_W'(FIFO_DEPTH)) |=> !haveSpace);
endmodule

// File: rtl/pkt_write_rx.sv
module pkt_write_rx
  import pkt_write_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PKT_WORDS  = 256,
  parameter int FIFO_DEPTH = 4096,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrStrobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [LVL_W-1:0]  fifoLevel,
  output logic              fifoWrReq,
  output logic [WORD_W-1:0] fifoWrData,
  output logic              haveSpace
);
  ctlStrobes_t ctlBus;

  pkt_write_ctl #(.PKT_WORDS(PKT_WORDS)) u_ctl (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .ctlOut(ctlBus)
  );

  pkt_write_dp #(.WORD_W(WORD_W), .PKT_WORDS(PKT_WORDS), .FIFO_DEPTH(FIFO_DEPTH)) u_dp (
    .clk(clk), .rst(rst), .ctlIn(ctlBus), .wrData(wrData), .fifoLevel(fifoLevel),
    .fifoWrReq(fifoWrReq), .fifoWrData(fifoWrData), .haveSpace(haveSpace)
  );

  // R2/R1: a write request always has a strobe behind it, never in reset
  p_req_src_r2: assert property (@(posedge clk)
    fifoWrReq |-> (wrStrobe && !rst));
  // R4: forwarded data tracks input data
  p_data_r4: assert property (@(posedge clk) disable iff (rst)
    fifoWrReq |-> (fifoWrData == wrData));
endmodule

// File: tb/pkt_write_rx_tb.sv
`timescale 1ns/1ps
module pkt_write_rx_tb;
  localparam int WW = 16;
  localparam int PK = 8;
  localparam int DP = 32;
  localparam int LW = $clog2(DP + 1);

  logic clk = 0;
  logic rst = 1;
  logic wrStrobe = 0;
  logic [WW-1:0] wrData = '0;
  logic [LW-1:0] fifoLevel = '0;
  logic fifoWrReq, haveSpace;
  logic [WW-1:0] fifoWrData;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pkt_write_rx #(.WORD_W(WW), .PKT_WORDS(PK), .FIFO_DEPTH(DP)) u_dut (
    .clk(clk), .rst(rst), .wrStrobe(wrStrobe), .wrData(wrData), .fifoLevel(fifoLevel),
    .fifoWrReq(fifoWrReq), .fifoWrData(fifoWrData), .haveSpace(haveSpace)
  );

  task automatic check(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one strobe-high clock; expWr says whether a FIFO write is expected
  task automatic word(input logic [WW-1:0] d, input bit expWr, input string req);
    @(negedge clk);
    wrStrobe = 1; wrData = d;
    #1;
    check(req, {15'd0, fifoWrReq}, {15'd0, expWr});
    if (expWr) check("R4", fifoWrData, d);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wrStrobe = 0;
      #1;
      check("R5", {15'd0, fifoWrReq}, 16'd0);
    end
  endtask

  task automatic packet(input int base, input int startIdx, input string req);
    for (int i = startIdx; i <= PK; i++)
      word(WW'(base * 37 + i * 11), (i < PK), (i < PK) ? req : "R3");
  endtask

  initial begin
    // R1: reset holds off writes even with the strobe high
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wrStrobe = 1; wrData = WW'(16'hA5A0 + i);
      #1;
      check("R1", {15'd0, fifoWrReq}, 16'd0);
    end
    check("R1", {15'd0, haveSpace}, 16'd0);
    @(negedge clk);
    rst = 0; wrStrobe = 0;

    // R2, R3, R4: full packets
    packet(1, 0, "R2");
    idle(1);
    // R6: one idle clock, then zero gap
    packet(2, 0, "R6");
    idle(1);
    packet(3, 0, "R6");
    packet(4, 0, "R6");
    idle(2);

    // R5: pause partway through a packet
    for (int i = 0; i < 3; i++) word(WW'(16'h0500 + i), 1'b1, "R5");
    idle(3);
    packet(5, 3, "R5");
    idle(1);

    // R8: reset partway through a packet
    for (int i = 0; i < 5; i++) word(WW'(16'h0800 + i), 1'b1, "R8");
    @(negedge clk);
    rst = 1; wrStrobe = 1;
    #1;
    check("R8", {15'd0, fifoWrReq}, 16'd0);
    @(negedge clk);
    rst = 0; wrStrobe = 0;
    packet(6, 0, "R8");
    idle(1);

    // R7: sweep every fill level
    for (int lv = 0; lv <= DP; lv++) begin
      @(negedge clk);
      fifoLevel = LW'(lv);
      @(negedge clk);
      #1;
      check("R7", {15'd0, haveSpace}, {15'd0, ((DP - lv) >= PK)});
    end

    // R1: reset clears the flag even with room
    @(negedge clk);
    fifoLevel = '0;
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    #1;
    check("R1", {15'd0, haveSpace}, 16'd0);
    rst = 0;

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule